// File: doc/BRIEF.md
# Framing Error Counter Selector

This unit sits behind the receive framer of a DS3/E3 line interface and counts overhead errors. Each clock it may receive single-cycle event pulses from the framer: entry into the out-of-frame (OOF) state, a framing F-bit error, a multiframe M-bit error, a count of E3 frame-alignment-signal (FAS) bit errors, a whole FAS word error, and P-bit parity, CP-bit parity and far-end block error (FEBE) events. It keeps four saturating counters: frame errors, P-parity errors, CP-parity errors and FEBE events.

What the frame-error counter counts depends on a 2-bit select field and on the line mode (DS3 or E3). A gating control decides whether overhead errors are counted while the framer reports OOF. A single latch strobe copies all four counters into holding outputs and restarts the counters in the same cycle, so no event is lost between reading and clearing.

Top module: `fe_count_sel`

## Requirements
- R1: After reset all four held counts are 0 and `illegal_cfg` is 0.
- R2: With `fe_sel` = 00, the frame-error counter adds 1 for each `ev_oof_entry` pulse in both modes, and `oof_now` does not gate it.
- R3: In DS3 mode (`e3_mode` = 0) with `fe_sel` = 01, the frame-error counter adds `ev_fbit` + `ev_mbit`, so a cycle with both adds 2.
- R4: In DS3 mode, `fe_sel` = 10 counts only `ev_fbit`, and `fe_sel` = 11 counts only `ev_mbit`.
- R5: In E3 mode (`e3_mode` = 1) with `fe_sel` = 01, the frame-error counter adds the value on `fas_bit_errs` (0 to 10) each cycle.
- R6: In E3 mode with `fe_sel` = 10, the frame-error counter adds 1 for each `ev_fas_word` pulse.
- R7: In E3 mode with `fe_sel` = 11, `illegal_cfg` is 1 and the frame-error counter does not change except by a latch strobe. In every other combination `illegal_cfg` is 0.
- R8: While `oof_now` = 1 and `oof_gate_en` = 0, the P, CP and FEBE counters, and the frame-error counter under `fe_sel` other than 00, do not increment. With `oof_gate_en` = 1 they count during OOF.
- R9: Every counter saturates at 2^CNT_W - 1 (65535 by default) and does not wrap.
- R10: On a cycle with `latch_stb` = 1, each held output takes the counter value from before that cycle, and each counter restarts at that cycle's own increment.
- R11: The P, CP and FEBE counters each add 1 per pulse of `ev_pbit`, `ev_cpbit` and `ev_febe`, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| e3_mode | input | 1 | 0 = DS3, 1 = E3 |
| fe_sel | input | 2 | Frame-error count select |
| oof_gate_en | input | 1 | 1 = count overhead errors during OOF |
| oof_now | input | 1 | Framer currently out of frame |
| ev_oof_entry | input | 1 | OOF entry pulse |
| ev_fbit | input | 1 | DS3 F-bit error pulse |
| ev_mbit | input | 1 | DS3 M-bit error pulse |
| fas_bit_errs | input | FAS_W (4) | E3 FAS bit errors this frame, 0 to 10 |
| ev_fas_word | input | 1 | E3 FAS word error pulse |
| ev_pbit | input | 1 | P-bit parity error pulse |
| ev_cpbit | input | 1 | CP-bit parity error pulse |
| ev_febe | input | 1 | FEBE event pulse |
| latch_stb | input | 1 | Capture and restart all counters |
| fe_hold | output | CNT_W (16) | Latched frame-error count |
| p_hold | output | CNT_W (16) | Latched P-parity count |
| cp_hold | output | CNT_W (16) | Latched CP-parity count |
| febe_hold | output | CNT_W (16) | Latched FEBE count |
| illegal_cfg | output | 1 | E3 mode with select 11 |

## Verification
The bench drives a coincident F-bit and M-bit error, where a design that ORs the pulses would count 1 instead of 2, and full 10-error FAS frames, where a truncated adder would lose the high bit. It runs OOF with gating off under select 00 and under the error selects, catching a design that gates OOF counting or that forgets to gate one of the four counters. It pushes the counter to its ceiling to catch wrap-around, and it strobes the latch on cycles that also carry events, where a design that clears to zero instead of to the new increment would drop those events; E3 select 11 is run to show the counter holds.

// File: rtl/fe_count_sel.sv
module fe_count_sel #(
  parameter int CNT_W = 16,
  parameter int FAS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             e3_mode,
  input  logic [1:0]       fe_sel,
  input  logic             oof_gate_en,
  input  logic             oof_now,
  input  logic             ev_oof_entry,
  input  logic             ev_fbit,
  input  logic             ev_mbit,
  input  logic [FAS_W-1:0] fas_bit_errs,
  input  logic             ev_fas_word,
  input  logic             ev_pbit,
  input  logic             ev_cpbit,
  input  logic             ev_febe,
  input  logic             latch_stb,
  output logic [CNT_W-1:0] fe_hold,
  output logic [CNT_W-1:0] p_hold,
  output logic [CNT_W-1:0] cp_hold,
  output logic [CNT_W-1:0] febe_hold,
  output logic             illegal_cfg
);
  localparam int INC_W = FAS_W + 1;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] fe_cnt, p_cnt, cp_cnt, febe_cnt;
  logic [INC_W-1:0] fe_inc;
  logic             blk;

  assign blk         = oof_now & ~oof_gate_en;
  assign illegal_cfg = e3_mode & (fe_sel == 2'b11);

  always_comb begin
    fe_inc = '0;
    unique case (fe_sel)
      2'b00: fe_inc = INC_W'(ev_oof_entry);
      2'b01: fe_inc = e3_mode ? INC_W'(fas_bit_errs)
                              : INC_W'(ev_fbit) + INC_W'(ev_mbit);
      2'b10: fe_inc = e3_mode ? INC_W'(ev_fas_word) : INC_W'(ev_fbit);
      2'b11: fe_inc = e3_mode ? '0 : INC_W'(ev_mbit);
    endcase
    if (blk && fe_sel != 2'b00) fe_inc = '0;
  end

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [INC_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + (CNT_W+1)'(b);
    return s[CNT_W] ? CMAX : s[CNT_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] next_cnt(input logic [CNT_W-1:0] c,
                                                input logic [INC_W-1:0] inc,
                                                input logic latch);
    return latch ? sat_add('0, inc) : sat_add(c, inc);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fe_cnt <= '0; p_cnt <= '0; cp_cnt <= '0; febe_cnt <= '0;
      fe_hold <= '0; p_hold <= '0; cp_hold <= '0; febe_hold <= '0;
    end else begin
      fe_cnt   <= next_cnt(fe_cnt, fe_inc, latch_stb);
      p_cnt    <= next_cnt(p_cnt, INC_W'(ev_pbit & ~blk), latch_stb);
      cp_cnt   <= next_cnt(cp_cnt, INC_W'(ev_cpbit & ~blk), latch_stb);
      febe_cnt <= next_cnt(febe_cnt, INC_W'(ev_febe & ~blk), latch_stb);
      if (latch_stb) begin
        fe_hold   <= fe_cnt;
        p_hold    <= p_cnt;
        cp_hold   <= cp_cnt;
        febe_hold <= febe_cnt;
      end
    end
  end
endmodule

module fe_count_sel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             e3_mode,
  input logic [1:0]       fe_sel,
  input logic             oof_gate_en,
  input logic             oof_now,
  input logic             latch_stb,
  input logic             ev_oof_entry,
  input logic             illegal_cfg,
  input logic [CNT_W-1:0] fe_cnt,
  input logic [CNT_W-1:0] p_cnt,
  input logic [CNT_W-1:0] cp_cnt,
  input logic [CNT_W-1:0] febe_cnt,
  input logic [CNT_W-1:0] fe_hold
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  assert_illegal_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (e3_mode && fe_sel == 2'b11 && !latch_stb) |=> fe_cnt == $past(fe_cnt));

  assert_illegal_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cfg == (e3_mode && fe_sel == 2'b11));

  assert_oof_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oof_now && !oof_gate_en && !latch_stb) |=>
      (p_cnt == $past(p_cnt) && cp_cnt == $past(cp_cnt) && febe_cnt == $past(febe_cnt)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_cnt == CMAX && !latch_stb) |=> fe_cnt == CMAX);

  assert_latch_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> fe_hold == $past(fe_cnt));

  assert_oof_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_sel == 2'b00 && ev_oof_entry && !latch_stb && fe_cnt != CMAX) |=>
      fe_cnt == $past(fe_cnt) + 1'b1);
endmodule

bind fe_count_sel fe_count_sel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .e3_mode(e3_mode), .fe_sel(fe_sel),
  .oof_gate_en(oof_gate_en), .oof_now(oof_now), .latch_stb(latch_stb),
  .ev_oof_entry(ev_oof_entry), .illegal_cfg(illegal_cfg),
  .fe_cnt(fe_cnt), .p_cnt(p_cnt), .cp_cnt(cp_cnt), .febe_cnt(febe_cnt),
  .fe_hold(fe_hold)
);

// File: tb/fe_count_sel_tb.sv
module fe_count_sel_tb;
  localparam int MAXV = 65535;

  logic clk = 0, rst_n = 0;
  logic e3_mode = 0, oof_gate_en = 0, oof_now = 0;
  logic [1:0] fe_sel = 0;
  logic ev_oof_entry = 0, ev_fbit = 0, ev_mbit = 0, ev_fas_word = 0;
  logic ev_pbit = 0, ev_cpbit = 0, ev_febe = 0, latch_stb = 0;
  logic [3:0] fas_bit_errs = 0;
  logic [15:0] fe_hold, p_hold, cp_hold, febe_hold;
  logic illegal_cfg;

  int total = 0, bad = 0;
  string cur_req = "R1";
  int m_cnt[4], m_hold[4];

  always #2 clk = ~clk;

  fe_count_sel u_dut (.*);

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  always @(posedge clk) begin
    int inc[4];
    bit blk;
    if (!rst_n) begin
      foreach (m_cnt[i]) begin m_cnt[i] = 0; m_hold[i] = 0; end
    end else begin
      blk = oof_now && !oof_gate_en;
      inc[0] = 0;
      if (fe_sel == 0) inc[0] = ev_oof_entry;
      else if (!blk) begin
        if (!e3_mode) begin
          if (fe_sel == 1) inc[0] = ev_fbit + ev_mbit;
          if (fe_sel == 2) inc[0] = ev_fbit;
          if (fe_sel == 3) inc[0] = ev_mbit;
        end else begin
          if (fe_sel == 1) inc[0] = fas_bit_errs;
          if (fe_sel == 2) inc[0] = ev_fas_word;
        end
      end
      inc[1] = blk ? 0 : ev_pbit;
      inc[2] = blk ? 0 : ev_cpbit;
      inc[3] = blk ? 0 : ev_febe;
      foreach (m_cnt[i]) begin
        if (latch_stb) begin
          m_hold[i] = m_cnt[i];
          m_cnt[i] = inc[i];
        end else m_cnt[i] = sat(m_cnt[i] + inc[i]);
      end
    end
  end

  task automatic compare();
    check({cur_req, " fe"}, fe_hold, m_hold[0]);
    check({cur_req, " p"}, p_hold, m_hold[1]);
    check({cur_req, " cp"}, cp_hold, m_hold[2]);
    check({cur_req, " febe"}, febe_hold, m_hold[3]);
    check({cur_req, " illegal"}, illegal_cfg, (e3_mode && fe_sel == 3));
  endtask

  task automatic quiet();
    ev_oof_entry = 0; ev_fbit = 0; ev_mbit = 0; ev_fas_word = 0;
    ev_pbit = 0; ev_cpbit = 0; ev_febe = 0; fas_bit_errs = 0; latch_stb = 0;
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic rand_run(int n, bit gate_oof);
    for (int k = 0; k < n; k++) begin
      ev_oof_entry = $urandom % 2; ev_fbit = $urandom % 2; ev_mbit = $urandom % 2;
      ev_fas_word = $urandom % 2; ev_pbit = $urandom % 2; ev_cpbit = $urandom % 2;
      ev_febe = $urandom % 2; fas_bit_errs = 4'($urandom % 11);
      oof_now = gate_oof ? ($urandom % 2) : 1'b0;
      latch_stb = ($urandom % 8) == 0;
      step();
    end
    quiet();
  endtask

  task automatic do_latch();
    latch_stb = 1; step(); latch_stb = 0; step();
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; step();
    check("R1 fe reset", fe_hold, 0);
    check("R1 illegal reset", illegal_cfg, 0);

    cur_req = "R3"; e3_mode = 0; fe_sel = 1;
    do_latch();
    ev_fbit = 1; ev_mbit = 1;
    repeat (4) step();
    quiet(); do_latch();
    check("R3 F+M coincident", fe_hold, 8);
    rand_run(200, 0);

    cur_req = "R4"; fe_sel = 2; rand_run(200, 0);
    fe_sel = 3; rand_run(200, 0);

    cur_req = "R2"; fe_sel = 0; oof_gate_en = 0; rand_run(200, 1);
    e3_mode = 1; rand_run(200, 1);

    cur_req = "R5"; fe_sel = 1; do_latch();
    fas_bit_errs = 10; repeat (3) step();
    quiet(); do_latch();
    check("R5 fas bits", fe_hold, 30);
    rand_run(200, 0);

    cur_req = "R6"; fe_sel = 2; rand_run(200, 0);

    cur_req = "R7"; fe_sel = 3; rand_run(200, 0);
    check("R7 flag", illegal_cfg, 1);
    do_latch();
    fas_bit_errs = 10; ev_fas_word = 1; repeat (5) step();
    quiet(); do_latch();
    check("R7 held", fe_hold, 0);

    cur_req = "R8"; oof_gate_en = 0; oof_now = 1; e3_mode = 0; fe_sel = 1;
    do_latch();
    ev_fbit = 1; ev_pbit = 1; ev_cpbit = 1; ev_febe = 1;
    repeat (5) step();
    quiet(); do_latch();
    check("R8 gated fe", fe_hold, 0);
    check("R8 gated p", p_hold, 0);
    oof_gate_en = 1;
    ev_fbit = 1; ev_febe = 1; repeat (5) step();
    quiet(); do_latch();
    check("R8 ungated fe", fe_hold, 5);
    check("R8 ungated febe", febe_hold, 5);
    rand_run(300, 1);
    oof_gate_en = 0; rand_run(300, 1);

    cur_req = "R11"; e3_mode = 1; fe_sel = 2; rand_run(200, 0);

    cur_req = "R10"; e3_mode = 0; fe_sel = 1; oof_now = 0; do_latch();
    ev_fbit = 1; ev_pbit = 1; repeat (3) step();
    latch_stb = 1; step();
    latch_stb = 0; quiet(); step();
    check("R10 captured", fe_hold, 3);
    do_latch();
    check("R10 strobe-cycle event kept", fe_hold, 1);
    check("R10 strobe-cycle p kept", p_hold, 1);

    cur_req = "R9"; e3_mode = 1; fe_sel = 1; ev_pbit = 1;
    fas_bit_errs = 10;
    repeat (6600) step();
    for (int k = 0; k < 66000 - 6600; k++) step();
    quiet(); do_latch();
    check("R9 fe saturated", fe_hold, MAXV);
    check("R9 p saturated", p_hold, MAXV);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule